// File: doc/BRIEF.md
# Polarity-Selectable Three-State Phase Frequency Detector

This block compares two pulse streams, a reference stream and a feedback stream, both sampled on a common clock. It drives a single-ended, three-state output toward an external charge pump and loop filter. The phase error appears as the width of a drive pulse, counted in clocks. The direction of the pulse shows whether the feedback stream lags or leads. When the two streams agree, the output floats and the loop filter holds the control voltage.

Each stream first passes through a parameterised synchronizer and a rising-edge detector. Each detected edge sets a flag of its own. While only one flag is set, the output is driven. Once both flags are set, they stay set together for a programmable minimum number of clocks and are then cleared as a pair. The output floats during that overlap. Because of this behaviour, even a one-clock phase difference gives a one-clock pulse.

A polarity input swaps the source and sink directions. This lets the block match loops whose voltage-controlled oscillator has either gain sign.

Top module: `pfd_core`

## Requirements
- R1: While reset is asserted, src_en, snk_en and pin_oe are all 0, and both internal edge flags are clear.
- R2: With pol=0, a reference rising edge that comes d clocks before the feedback rising edge gives a source pulse (src_en=1) exactly d clocks wide.
- R3: With pol=0, a feedback rising edge that comes d clocks before the reference rising edge gives a sink pulse (snk_en=1) exactly d clocks wide.
- R4: With pol=1, the directions of R2 and R3 are swapped: a reference lead gives a sink pulse and a feedback lead gives a source pulse, each with the same width.
- R5: Rising edges on both inputs in the same clock give no drive: pin_oe stays 0 throughout.
- R6: There is no dead zone. A difference of one clock between the edges gives a drive pulse exactly one clock wide.
- R7: src_en and snk_en are never 1 together. pin_oe=1 exactly when one of them is 1. While pin_oe=1, pin_val=1 means source and pin_val=0 means sink.
- R8: Once both flags are set, they stay set together for at least MIN_OVERLAP clocks and the output floats during that time. They are then cleared together. An edge detected in the clearing cycle sets its flag again and is not lost.
- R9: The first drive cycle comes SYNC_STAGES+1 clock edges after the input is driven high at a falling clock edge. In other words, the clock edge that first samples the input is followed by SYNC_STAGES more edges.
- R10: A further rising edge on an input whose flag is already set is ignored. When the feedback stream runs faster, the sink pulse lasts from the first feedback edge to the next reference edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_in | input | 1 | Reference pulse stream |
| fv_in | input | 1 | Feedback (divided oscillator) pulse stream |
| pol | input | 1 | Polarity: 0 = reference lead sources, 1 = reference lead sinks |
| src_en | output | 1 | Current-source enable |
| snk_en | output | 1 | Current-sink enable |
| pin_oe | output | 1 | Output-pin drive enable (0 = high impedance) |
| pin_val | output | 1 | Output-pin level while driven (1 = source, 0 = sink) |

## Verification
The bound checker checks, on every clock, the properties that can be written per cycle:
- source and sink are mutually exclusive;
- the pin is driven exactly when one flag is set, and its level matches the direction for the current polarity;
- a detected edge always sets its flag on the next clock;
- a clear happens only after both flags have been held for the minimum overlap.

Only the bench scenarios can show the pulse widths: leading, lagging, equal-phase, one-clock and fast-feedback edge pairs are run under both polarities and measured in clocks. The same scenarios show the start latency and the re-arming of a flag in the clearing cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    DRV_FLOAT  = 2'b00,
    DRV_SOURCE = 2'b01,
    DRV_SINK   = 2'b10
  } drv_e;

  // Direction chosen from which flag is alone and the polarity bit.
  function automatic drv_e pick_drive(input logic ref_only,
                                      input logic fb_only,
                                      input logic pol);
    if (ref_only)     return pol ? DRV_SINK : DRV_SOURCE;
    else if (fb_only) return pol ? DRV_SOURCE : DRV_SINK;
    else              return DRV_FLOAT;
  endfunction

  // Width of a counter that must reach limit.
  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic cur;
  logic prev;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign cur = din;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sh <= '0;
        end else begin
          sh[0] <= din;
          for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign cur = sh[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= cur;
  end

  assign rise = cur & ~prev;
endmodule

// File: rtl/pfd_flags.sv
module pfd_flags #(
  parameter int MIN_OVERLAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic fb_edge,
  output logic ref_q,
  output logic fb_q,
  output logic clr_evt
);
  import pfd_pkg::*;
  localparam int CW = cnt_bits(MIN_OVERLAP);

  logic [CW-1:0] ovl_cnt;
  logic          both;

  assign both    = ref_q & fb_q;
  assign clr_evt = both & (ovl_cnt == CW'(MIN_OVERLAP - 1));

  // A fresh edge wins over the clear so that it is never dropped.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      fb_q    <= 1'b0;
      ovl_cnt <= '0;
    end else begin
      ref_q   <= ref_edge | (ref_q & ~clr_evt);
      fb_q    <= fb_edge  | (fb_q  & ~clr_evt);
      ovl_cnt <= (both && !clr_evt) ? ovl_cnt + CW'(1) : '0;
    end
  end
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive (
  input  logic ref_q,
  input  logic fb_q,
  input  logic pol,
  output logic src_en,
  output logic snk_en,
  output logic pin_oe,
  output logic pin_val
);
  import pfd_pkg::*;
  drv_e drv;

  always_comb begin
    drv     = pick_drive(ref_q & ~fb_q, fb_q & ~ref_q, pol);
    src_en  = (drv == DRV_SOURCE);
    snk_en  = (drv == DRV_SINK);
    pin_oe  = (drv != DRV_FLOAT);
    pin_val = (drv == DRV_SOURCE);
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_OVERLAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fr_in,
  input  logic fv_in,
  input  logic pol,
  output logic src_en,
  output logic snk_en,
  output logic pin_oe,
  output logic pin_val
);
  // Named internal events, visible to the bound checker.
  logic ref_edge;
  logic fb_edge;
  logic ref_q;
  logic fb_q;
  logic clr_evt;

  pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst_n(rst_n), .din(fr_in), .rise(ref_edge)
  );

  pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fb_edge (
    .clk(clk), .rst_n(rst_n), .din(fv_in), .rise(fb_edge)
  );

  pfd_flags #(.MIN_OVERLAP(MIN_OVERLAP)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ref_edge(ref_edge), .fb_edge(fb_edge),
    .ref_q(ref_q), .fb_q(fb_q), .clr_evt(clr_evt)
  );

  pfd_drive u_drive (
    .ref_q(ref_q), .fb_q(fb_q), .pol(pol),
    .src_en(src_en), .snk_en(snk_en),
    .pin_oe(pin_oe), .pin_val(pin_val)
  );
endmodule

// File: rtl/pfd_core_chk.sv
module pfd_core_chk #(
  parameter int MIN_OVERLAP = 1
) (
  input logic clk,
  input logic rst_n,
  input logic pol,
  input logic ref_edge,
  input logic fb_edge,
  input logic ref_q,
  input logic fb_q,
  input logic clr_evt,
  input logic src_en,
  input logic snk_en,
  input logic pin_oe,
  input logic pin_val
);
  logic [15:0] both_run;

  always_ff @(posedge clk) begin
    if (!rst_n)              both_run <= '0;
    else if (ref_q && fb_q)  both_run <= (both_run == 16'hFFFF) ? both_run : both_run + 16'd1;
    else                     both_run <= '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!ref_q && !fb_q && !pin_oe));

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_en && snk_en));

  p_drive_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q ^ fb_q) |-> pin_oe);

  p_float_else_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_q ^ fb_q) |-> !pin_oe);

  p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (pin_val == src_en));

  p_ref_lead_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q && !fb_q && !pol) |-> src_en);

  p_fb_lead_sink_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_q && !ref_q && !pol) |-> snk_en);

  p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q && !fb_q && pol) |-> snk_en);

  p_ref_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |=> ref_q);

  p_fb_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fb_edge |=> fb_q);

  p_clear_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |-> (ref_q && fb_q));

  p_overlap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |-> (both_run >= 16'(MIN_OVERLAP - 1)));
endmodule

bind pfd_core pfd_core_chk #(.MIN_OVERLAP(MIN_OVERLAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol(pol),
  .ref_edge(ref_edge), .fb_edge(fb_edge),
  .ref_q(ref_q), .fb_q(fb_q), .clr_evt(clr_evt),
  .src_en(src_en), .snk_en(snk_en), .pin_oe(pin_oe), .pin_val(pin_val)
);

// File: tb/tb_pfd_core.sv
`timescale 1ns/1ps
module tb_pfd_core;
  localparam int SYNC = 2;
  localparam int MINO = 1;
  localparam int LAT  = SYNC + 1;
  localparam int WIN  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr_in = 1'b0, fv_in = 1'b0, pol = 1'b0;
  logic src_en, snk_en, pin_oe, pin_val;

  int checks = 0;
  int errors = 0;
  logic [WIN-1:0] s_src, s_snk, s_oe;
  int n_src, n_snk, n_both, n_lvl, first_drv;

  always #2 clk = ~clk;

  pfd_core #(.SYNC_STAGES(SYNC), .MIN_OVERLAP(MINO)) dut (
    .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .fv_in(fv_in), .pol(pol),
    .src_en(src_en), .snk_en(snk_en), .pin_oe(pin_oe), .pin_val(pin_val)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WIN-1:0] pulse(input int t);
    return WIN'(2'b11) << t;
  endfunction

  // Step i: sample state after i edges, then drive step-i inputs.
  task automatic run_seq(input logic [WIN-1:0] rp, input logic [WIN-1:0] fp, input logic p);
    pol = p; n_src = 0; n_snk = 0; n_both = 0; n_lvl = 0; first_drv = -1;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      s_src[i] = src_en; s_snk[i] = snk_en; s_oe[i] = pin_oe;
      if (src_en) n_src++;
      if (snk_en) n_snk++;
      if (src_en && snk_en) n_both++;
      if (pin_oe != (src_en | snk_en) || (pin_oe && pin_val != src_en)) n_lvl++;
      if (pin_oe && first_drv < 0) first_drv = i;
      fr_in = rp[i]; fv_in = fp[i];
    end
    fr_in = 1'b0; fv_in = 1'b0;
    check(n_both == 0, "R7 exclusive", n_both, 0);
    check(n_lvl == 0, "R7 pin encoding", n_lvl, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fr_in = 1'b1; fv_in = 1'b0;
    repeat (5) @(negedge clk);
    check(!pin_oe && !src_en && !snk_en, "R1 reset float", pin_oe, 0);
    fr_in = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!pin_oe, "R1 idle after reset", pin_oe, 0);
  endtask

  task automatic t_ref_lead_pol0();
    run_seq(pulse(2), pulse(7), 1'b0);
    check(n_src == 5, "R2 source width", n_src, 5);
    check(n_snk == 0, "R2 no sink", n_snk, 0);
    check(first_drv == 2 + LAT, "R9 start latency", first_drv, 2 + LAT);
  endtask

  task automatic t_fb_lead_pol0();
    run_seq(pulse(6), pulse(2), 1'b0);
    check(n_snk == 4, "R3 sink width", n_snk, 4);
    check(n_src == 0, "R3 no source", n_src, 0);
  endtask

  task automatic t_pol1();
    run_seq(pulse(2), pulse(7), 1'b1);
    check(n_snk == 5 && n_src == 0, "R4 ref lead sinks", n_snk, 5);
    run_seq(pulse(6), pulse(2), 1'b1);
    check(n_src == 4 && n_snk == 0, "R4 fb lead sources", n_src, 4);
  endtask

  task automatic t_equal();
    run_seq(pulse(3), pulse(3), 1'b0);
    check(s_oe == '0, "R5 equal phase float", n_src + n_snk, 0);
    run_seq(pulse(3), pulse(3), 1'b1);
    check(s_oe == '0, "R5 equal phase float pol1", n_src + n_snk, 0);
  endtask

  task automatic t_dead_zone();
    run_seq(pulse(4), pulse(5), 1'b0);
    check(n_src == 1 && n_snk == 0, "R6 one-clock source", n_src, 1);
    run_seq(pulse(5), pulse(4), 1'b0);
    check(n_snk == 1 && n_src == 0, "R6 one-clock sink", n_snk, 1);
  endtask

  task automatic t_fast_fb();
    run_seq(pulse(6), pulse(0) | pulse(3), 1'b0);
    check(n_snk == 6, "R10 repeated fb edge ignored", n_snk, 6);
    check(n_src == 0, "R10 no source", n_src, 0);
  endtask

  task automatic t_rearm();
    run_seq(pulse(0) | pulse(3), pulse(2) | pulse(8), 1'b0);
    check(n_src == 7, "R8 total source", n_src, 7);
    check(!s_oe[2 + LAT], "R8 float in overlap", s_oe[2 + LAT], 0);
    check(s_src[3 + LAT], "R8 edge in clear cycle kept", s_src[3 + LAT], 1);
    check(!s_oe[8 + LAT + 1], "R8 cleared after overlap", s_oe[8 + LAT + 1], 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ref_lead_pol0();
    t_fb_lead_pol0();
    t_pol1();
    t_equal();
    t_dead_zone();
    t_fast_fb();
    t_rearm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule